// File: doc/BRIEF.md
# Debug Port Transfer Address Auto-Incrementer

This block holds the transfer address of a debug memory access port, which carries a debugger's requests onto a system bus. Software running on the debugger programs a control word and a starting address through register writes. The address then steps forward by itself after each completed access to the data register, so a debugger can stream a block of memory without rewriting the address each time.

The step size depends on a two-bit increment mode and a three-bit access size, both held in the control word. Only the low address bits inside an aligned page take part in the increment. The page is `PAGE_BYTES` long and is set at build time to 1 KB or 4 KB. The bits above the page never carry. A block transfer that runs past the end of a page therefore wraps back to the start of the same page and reads the same data again. The debugger avoids this by splitting a long transfer into page-sized pieces and reloading the address before each piece.

Top module: `dap_addr_incr`

## Requirements
- R1: After reset the address is 0, the access size is word (code 010) and the increment mode is none (00).
- R2: A register write at offset 0x0 loads the control word: the increment mode comes from bits [5:4] and the access size from bits [2:0]. A register write at offset 0x4 loads the address.
- R3: With mode 00, a completed data access leaves the address unchanged.
- R4: With mode 01, a completed data access adds the access-size step. Size code 000 gives a step of 1, code 001 gives 2, and every other code gives 4.
- R5: With mode 10 (packed), a completed data access adds 4, whatever the access size.
- R6: With mode 11 (reserved), a completed data access leaves the address unchanged.
- R7: The address changes only on a cycle where the done strobe is high and the access targets the data register, or on an address write. A done strobe for any other register has no effect.
- R8: An increment changes only the low log2(`PAGE_BYTES`) bits, modulo the page size. The upper bits keep their value, so a word stream starting at 0x1400 with 1 KB pages reaches 0x17FC and then returns to 0x1400.
- R9: An address write in the same cycle as a completed data access wins: the address takes the written value in full.
- R10: A control write in the same cycle as a completed data access takes effect only from the next cycle. The increment in that cycle uses the previous mode and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 4 | Register offset (0x0 control word, 0x4 address) |
| cfg_wdata | input | ADDR_W | Register write data |
| xfer_done | input | 1 | Access-complete strobe |
| xfer_data | input | 1 | High when the completed access targeted the data register |
| bus_addr | output | ADDR_W | Current transfer address |

## Verification
Two kinds of event can land in the same cycle, and the bench drives both collisions on purpose, in one cycle each.

- **Address write and increment.** An address load arrives in the same cycle as a completed data access. The check confirms that the loaded value survives untouched by the step.
- **Control write and increment.** A new control word arrives in the same cycle as a completed data access. The check confirms that this cycle's step follows the old mode and size, and that the next access follows the new ones.

A behavioural model in the bench works out the address from page arithmetic on integers and is compared on every clock. It is compared most closely at the page-end wrap and across a 4 KB stream.

// File: rtl/dap_addr_incr.sv
module dap_addr_incr #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_off,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              xfer_done,
  input  logic              xfer_data,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam int         PG_W     = $clog2(PAGE_BYTES);
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_ADDR = 4'h4;

  logic [1:0]      inc_mode;
  logic [2:0]      acc_size;
  logic [PG_W-1:0] step;
  logic [PG_W-1:0] low_next;
  logic            ctrl_wr, addr_wr, bump;

  assign ctrl_wr  = cfg_wr && (cfg_off == OFF_CTRL);
  assign addr_wr  = cfg_wr && (cfg_off == OFF_ADDR);
  assign bump     = xfer_done && xfer_data;
  assign low_next = bus_addr[PG_W-1:0] + step;

  always_comb begin
    case (inc_mode)
      2'b01: begin
        case (acc_size)
          3'b000:  step = PG_W'(1);
          3'b001:  step = PG_W'(2);
          default: step = PG_W'(4);
        endcase
      end
      2'b10:   step = PG_W'(4);
      default: step = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_mode <= 2'b00;
      acc_size <= 3'b010;
    end else if (ctrl_wr) begin
      inc_mode <= cfg_wdata[5:4];
      acc_size <= cfg_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr <= '0;
    end else if (addr_wr) begin
      bus_addr <= cfg_wdata;
    end else if (bump) begin
      bus_addr[PG_W-1:0] <= low_next;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_wr && !bump) |=> $stable(bus_addr));

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr |=> $stable(bus_addr[ADDR_W-1:PG_W]));

  // R9
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (bus_addr == $past(cfg_wdata)));

  // R3
  no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && !addr_wr && inc_mode == 2'b00) |=> $stable(bus_addr));
endmodule

// File: tb/test_dap_addr_incr.sv
module test_dap_addr_incr;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 32;
  localparam int PAGE = 1024;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_wr = 0;
  logic [3:0]    cfg_off = 0;
  logic [AW-1:0] cfg_wdata = 0;
  logic          xfer_done = 0;
  logic          xfer_data = 0;
  logic [AW-1:0] bus_addr;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  longint m_addr = 0;
  int m_mode = 0;
  int m_size = 2;

  always #(CLK_PERIOD/2) clk = ~clk;

  dap_addr_incr #(.ADDR_W(AW), .PAGE_BYTES(PAGE)) i_dap_addr_incr (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off),
    .cfg_wdata(cfg_wdata), .xfer_done(xfer_done), .xfer_data(xfer_data),
    .bus_addr(bus_addr));

  function automatic longint model_next(longint a, int mode, int size);
    longint stp, base;
    if (mode == 1) stp = (size == 0) ? 1 : (size == 1) ? 2 : 4;
    else if (mode == 2) stp = 4;
    else stp = 0;
    base = a - (a % PAGE);
    return base + ((a % PAGE + stp) % PAGE);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr <= 0; m_mode <= 0; m_size <= 2;
    end else begin
      if (cfg_wr && cfg_off == 4'h0) begin
        m_mode <= int'(cfg_wdata[5:4]);
        m_size <= int'(cfg_wdata[2:0]);
      end
      if (cfg_wr && cfg_off == 4'h4) m_addr <= longint'(cfg_wdata);
      else if (xfer_done && xfer_data) m_addr <= model_next(m_addr, m_mode, m_size);
    end
  end

  task automatic chk(input logic ok, input string t, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n) chk(bus_addr == m_addr[AW-1:0], {tag, " model"}, bus_addr, m_addr);

  task automatic idle();
    @(negedge clk);
    cfg_wr = 0; xfer_done = 0; xfer_data = 0;
  endtask

  task automatic wr(input logic [3:0] off, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_off = off; cfg_wdata = d; xfer_done = 0;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic ctrl(input int mode, input int size);
    wr(4'h0, AW'((mode << 4) | size));
  endtask

  task automatic access(input int n, input logic dsel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      xfer_done = 1; xfer_data = dsel;
    end
    @(negedge clk);
    xfer_done = 0; xfer_data = 0;
  endtask

  task automatic expect_addr(input string t, input longint e);
    @(negedge clk);
    chk(bus_addr == e[AW-1:0], t, bus_addr, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1";
    expect_addr("R1 reset address", 0);
    access(3, 1);
    expect_addr("R1 default no increment", 0);

    tag = "R2";
    wr(4'h4, 32'h0000_1400);
    expect_addr("R2 address load", 32'h1400);

    tag = "R8";
    ctrl(1, 2);
    access(255, 1);
    expect_addr("R8 page end", 32'h17FC);
    access(1, 1);
    expect_addr("R8 wrap to page start", 32'h1400);
    wr(4'h4, 32'hABCD_17FC);
    access(1, 1);
    expect_addr("R8 upper bits kept", 32'hABCD_1400);

    tag = "R4";
    wr(4'h4, 32'h1400);
    ctrl(1, 0); access(3, 1);
    expect_addr("R4 byte step", 32'h1403);
    ctrl(1, 1); access(2, 1);
    expect_addr("R4 halfword step", 32'h1407);
    ctrl(1, 3); access(1, 1);
    expect_addr("R4 other size step 4", 32'h140B);

    tag = "R5";
    ctrl(2, 0); access(2, 1);
    expect_addr("R5 packed step 4", 32'h1413);

    tag = "R6";
    ctrl(3, 2); access(4, 1);
    expect_addr("R6 reserved mode", 32'h1413);

    tag = "R3";
    ctrl(0, 2); access(4, 1);
    expect_addr("R3 mode none", 32'h1413);

    tag = "R7";
    ctrl(1, 2); access(5, 0);
    expect_addr("R7 non-data done ignored", 32'h1413);

    tag = "R9";
    @(negedge clk);
    cfg_wr = 1; cfg_off = 4'h4; cfg_wdata = 32'h0000_3000; xfer_done = 1; xfer_data = 1;
    idle();
    chk(bus_addr == 32'h3000, "R9 write beats increment", bus_addr, 32'h3000);

    tag = "R10";
    @(negedge clk);
    cfg_wr = 1; cfg_off = 4'h0; cfg_wdata = 32'h0; xfer_done = 1; xfer_data = 1;
    idle();
    chk(bus_addr == 32'h3004, "R10 old control used", bus_addr, 32'h3004);
    access(1, 1);
    expect_addr("R10 new control after", 32'h3004);

    tag = "R8";
    wr(4'h4, 32'h2000); ctrl(1, 2);
    access(1024, 1);
    expect_addr("R8 4KB stream repeats page", 32'h2000);
    wr(4'h4, 32'h2400); access(10, 1);
    expect_addr("R8 reload next page", 32'h2428);

    idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule